// File: doc/BRIEF.md
# Full-Duplex Serial Shift Port with Master and Slave Modes

This block moves 8-bit frames over a four-wire synchronous serial link: a clock line, a data line in each direction, and an active-low select. One internal shift register sends and receives together, so every frame swaps a byte in each direction. A small register interface lets a processor set the mode, read status, load the byte to send and pick up the byte received.

As bus master, the block makes its serial clock from the system clock through a prescaler. It pulls its select output low for the whole frame. As slave, it follows an external serial clock while the external select is low. It drives its data output only while that select is low. The external clock, select and data inputs pass through synchronisers, so a slave clock must be much slower than the system clock.

Register map (address on `bus_addr`): 0 = control, 1 = status (read only), 2 = data (a write loads the byte to send, a read returns the last byte received). Control bits: [0] enable, [1] master when 1, [2] least-significant bit first when 1, [4:3] rate select, [5] double speed, [7:6] spare storage. Status bits: [7] frame done, [6] write collision, the other bits read 0.

Top module: `spi_port_ctrl`

## Requirements
- R1: In master mode with control bit 2 clear, a write to address 2 sends the byte most-significant bit first on `mosi_o`. The bits sampled from `miso_i` fill the received byte, which a read of address 2 returns after the frame.
- R2: With control bit 2 set, both the sent and the received bytes are ordered least-significant bit first.
- R3: A master frame lasts exactly 8 x D system clocks, with `ss_n_o` held low for all of them. D is 4, 16, 64 or 128 for rate select 0..3 with bit 5 clear, and half of that with bit 5 set.
- R4: `sck_o` rests low between frames and gives exactly 8 pulses per frame. `mosi_o` never changes in the cycle where `sck_o` rises.
- R5: Status bit 7 is set when the eighth bit of a frame has been shifted. The received byte stays readable, unchanged, until the next frame completes.
- R6: Status bits 7 and 6 are cleared only by a read of address 1 followed by an access to address 2. An access to address 2 without that earlier status read leaves them set.
- R7: A write to address 2 during a frame sets status bit 6 and leaves the byte being shifted untouched.
- R8: In slave mode, with `ss_n_i` low, the block samples `mosi_i` on rising `sck_i` and shifts on falling `sck_i`. It shows its loaded byte on `miso_o` and sets status bit 7 after eight bits.
- R9: In slave mode, if `ss_n_i` rises mid-frame, the partial frame is dropped: status bit 7 stays clear, and the next full frame is received correctly.
- R10: `miso_oe` is high only in enabled slave mode while `ss_n_i` is low.
- R11: With control bit 0 clear, a write to address 2 starts no frame: `ss_n_o` stays high and `sck_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (drives flag clearing) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| sck_o | output | 1 | Serial clock output (master) |
| mosi_o | output | 1 | Serial data out (master) |
| miso_i | input | 1 | Serial data in (master) |
| ss_n_o | output | 1 | Select output, low during a master frame |
| sck_i | input | 1 | Serial clock input (slave) |
| mosi_i | input | 1 | Serial data in (slave) |
| ss_n_i | input | 1 | Select input, active low (slave) |
| miso_o | output | 1 | Serial data out (slave) |
| miso_oe | output | 1 | Output enable for `miso_o` |

## Verification
Master frames run with random bytes in both directions, across every rate select and double-speed setting, in both bit orders. A swapped order or a wrong divisor then shows up as a wrong byte or a wrong frame length. Directed cases cover a data write during a frame, which must raise the collision flag and leave the outgoing byte intact, and the flag-clearing order, which tells a bare data access apart from a status-then-data sequence. Slave frames use random bytes in both orders, plus a frame cut short by select, which separates a proper counter reset from a frame that merely picks up where it stopped.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  typedef struct packed {
    logic [1:0] spare;
    logic       dbl;
    logic [1:0] rate;
    logic       lsb_first;
    logic       master;
    logic       enable;
  } ctrl_t;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_STAT = 2'd1;
  localparam logic [1:0] A_DATA = 2'd2;

  // Full serial-clock period in system clocks.
  function automatic logic [7:0] spi_divisor(input logic [1:0] sel, input logic dbl);
    logic [7:0] base;
    case (sel)
      2'd0:    base = 8'd4;
      2'd1:    base = 8'd16;
      2'd2:    base = 8'd64;
      default: base = 8'd128;
    endcase
    return dbl ? (base >> 1) : base;
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RST_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
  import spi_port_pkg::*;
#(
  parameter int CW = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [1:0] sel,
  input  logic       dbl,
  output logic       tick
);
  logic [CW-1:0] cnt;
  logic [7:0]    div;
  logic [7:0]    half_m1;

  assign div     = spi_divisor(sel, dbl);
  assign half_m1 = (div >> 1) - 8'd1;
  assign tick    = run && (cnt == half_m1[CW-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run || tick) cnt <= '0;
    else                   cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/spi_shifter.sv
module spi_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] load_val,
  input  logic          lsb_first,
  input  logic          sample_evt,
  input  logic          sample_bit,
  input  logic          shift_evt,
  input  logic          clear,
  output logic          out_bit,
  output logic [DW-1:0] frame_word,
  output logic          last_shift,
  output logic          cnt_nz
);
  localparam int CW = (DW > 2) ? $clog2(DW) : 1;
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  logic [DW-1:0] sr;
  logic          cap;
  logic [CW-1:0] cnt;

  function automatic logic [DW-1:0] shift_word(input logic [DW-1:0] w, input logic b,
                                               input logic lsb);
    if (lsb) return {b, w[DW-1:1]};
    else     return {w[DW-2:0], b};
  endfunction

  assign out_bit    = lsb_first ? sr[0] : sr[DW-1];
  assign frame_word = shift_word(sr, cap, lsb_first);
  assign last_shift = shift_evt && (cnt == LAST);
  assign cnt_nz     = (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cap <= 1'b0;
      cnt <= '0;
    end else begin
      if (sample_evt) cap <= sample_bit;
      if (load) begin
        sr  <= load_val;
        cnt <= '0;
      end else if (clear) begin
        cnt <= '0;
      end else if (shift_evt) begin
        sr  <= frame_word;
        cnt <= last_shift ? '0 : cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/spi_flag_unit.sv
module spi_flag_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_done,
  input  logic set_wcol,
  input  logic stat_rd,
  input  logic data_acc,
  output logic done,
  output logic wcol
);
  logic arm_done, arm_wcol;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      arm_done <= 1'b0;
      arm_wcol <= 1'b0;
      done     <= 1'b0;
      wcol     <= 1'b0;
    end else begin
      if (stat_rd) begin
        arm_done <= done;
        arm_wcol <= wcol;
      end else if (data_acc) begin
        arm_done <= 1'b0;
        arm_wcol <= 1'b0;
      end
      done <= set_done | (done & ~(data_acc & arm_done));
      wcol <= set_wcol | (wcol & ~(data_acc & arm_wcol));
    end
  end
endmodule

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  parameter int RATE_CW     = 7
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] bus_addr,
  input  logic       bus_wr,
  input  logic       bus_rd,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  output logic       sck_o,
  output logic       mosi_o,
  input  logic       miso_i,
  output logic       ss_n_o,
  input  logic       sck_i,
  input  logic       mosi_i,
  input  logic       ss_n_i,
  output logic       miso_o,
  output logic       miso_oe
);
  localparam int NSYNC = 3;

  ctrl_t         ctrl;
  logic [DW-1:0] rx_buf;
  logic          m_busy, sck_m, sck_prev, mid;
  logic          tick, out_bit, last_shift, cnt_nz;
  logic [DW-1:0] frame_word;
  logic          done_flag, wcol_flag;

  // Slave-side synchronisers: bit 0 select, bit 1 data, bit 2 clock.
  logic [NSYNC-1:0] raw_in, syn_q;
  assign raw_in = {sck_i, mosi_i, ss_n_i};

  for (genvar g = 0; g < NSYNC; g++) begin : g_sync
    spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(g == 0)) i_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_in[g]), .q(syn_q[g]));
  end

  logic ss_q, mosi_q, sck_q;
  assign ss_q   = syn_q[0];
  assign mosi_q = syn_q[1];
  assign sck_q  = syn_q[2];

  // Mode and bus decode
  logic is_master, is_slave, slave_active;
  assign is_master    = ctrl.enable & ctrl.master;
  assign is_slave     = ctrl.enable & ~ctrl.master;
  assign slave_active = is_slave & ~ss_q;

  logic wr_ctrl, wr_data, stat_rd, data_acc;
  assign wr_ctrl  = bus_wr & (bus_addr == A_CTRL);
  assign wr_data  = bus_wr & (bus_addr == A_DATA);
  assign stat_rd  = bus_rd & (bus_addr == A_STAT);
  assign data_acc = (bus_rd | bus_wr) & (bus_addr == A_DATA);

  // Internal events, named for the checker
  logic m_rise, m_fall, s_rise, s_fall, in_progress, load, wcol_set, frame_done;
  assign m_rise      = tick & ~sck_m;
  assign m_fall      = tick & sck_m;
  assign s_rise      = slave_active & sck_q & ~sck_prev;
  assign s_fall      = slave_active & ~sck_q & sck_prev;
  assign in_progress = is_master ? m_busy : (slave_active & (cnt_nz | mid));
  assign load        = wr_data & ctrl.enable & ~in_progress;
  assign wcol_set    = wr_data & ctrl.enable & in_progress;
  assign frame_done  = last_shift;

  spi_rate_gen #(.CW(RATE_CW)) i_rate (
    .clk(clk), .rst_n(rst_n), .run(m_busy), .sel(ctrl.rate), .dbl(ctrl.dbl), .tick(tick));

  spi_shifter #(.DW(DW)) i_shift (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(bus_wdata[DW-1:0]),
    .lsb_first(ctrl.lsb_first),
    .sample_evt(is_master ? m_rise : s_rise),
    .sample_bit(is_master ? miso_i : mosi_q),
    .shift_evt(is_master ? m_fall : s_fall),
    .clear(~ctrl.enable | (is_slave & ss_q)),
    .out_bit(out_bit), .frame_word(frame_word), .last_shift(last_shift), .cnt_nz(cnt_nz));

  spi_flag_unit i_flags (
    .clk(clk), .rst_n(rst_n), .set_done(frame_done), .set_wcol(wcol_set),
    .stat_rd(stat_rd), .data_acc(data_acc), .done(done_flag), .wcol(wcol_flag));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl     <= '0;
      rx_buf   <= '0;
      m_busy   <= 1'b0;
      sck_m    <= 1'b0;
      sck_prev <= 1'b0;
      mid      <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl <= ctrl_t'(bus_wdata);
      if (frame_done) rx_buf <= frame_word;
      sck_prev <= sck_q;

      if (!is_master || last_shift) m_busy <= 1'b0;
      else if (load)                m_busy <= 1'b1;

      if (!m_busy)   sck_m <= 1'b0;
      else if (tick) sck_m <= ~sck_m;

      if (!slave_active) mid <= 1'b0;
      else if (s_rise)   mid <= 1'b1;
      else if (s_fall)   mid <= 1'b0;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTRL:  bus_rdata = ctrl;
      A_STAT:  bus_rdata = {done_flag, wcol_flag, 6'b0};
      A_DATA:  bus_rdata = 8'(rx_buf);
      default: bus_rdata = '0;
    endcase
  end

  assign sck_o   = sck_m;
  assign mosi_o  = is_master & out_bit;
  assign ss_n_o  = ~m_busy;
  assign miso_o  = out_bit;
  assign miso_oe = slave_active;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic clk,
  input logic rst_n,
  input logic m_busy,
  input logic sck_o,
  input logic load,
  input logic wcol_set,
  input logic frame_done,
  input logic done_flag,
  input logic miso_oe,
  input logic is_master
);
  p_sck_rest_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !m_busy |-> !sck_o);

  p_sck_moves_in_frame_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sck_o) |-> $past(m_busy));

  p_frame_starts_on_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(m_busy) |-> $past(load));

  p_collision_blocks_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wcol_set |-> !load);

  p_done_from_last_bit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> $past(frame_done));

  p_oe_slave_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
    miso_oe |-> !is_master);
endmodule

bind spi_port_ctrl spi_port_chk i_chk (
  .clk(clk), .rst_n(rst_n), .m_busy(m_busy), .sck_o(sck_o), .load(load),
  .wcol_set(wcol_set), .frame_done(frame_done), .done_flag(done_flag),
  .miso_oe(miso_oe), .is_master(is_master));

// File: tb/test_spi_port_ctrl.sv
module test_spi_port_ctrl;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic       sck_o, mosi_o, miso_i, ss_n_o, miso_o, miso_oe;
  logic       sck_i = 1'b0, mosi_i = 1'b0, ss_n_i = 1'b1;

  int n_checks = 0, n_fail = 0;

  always #5 clk = ~clk;

  spi_port_ctrl i_spi_port_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sck_o(sck_o), .mosi_o(mosi_o),
    .miso_i(miso_i), .ss_n_o(ss_n_o), .sck_i(sck_i), .mosi_i(mosi_i), .ss_n_i(ss_n_i),
    .miso_o(miso_o), .miso_oe(miso_oe));

  function automatic int exp_div(input logic [1:0] sel, input bit dbl);
    int d;
    d = (sel == 2'd3) ? 128 : (1 << (2 + 2 * int'(sel)));
    return dbl ? d / 2 : d;
  endfunction

  function automatic logic bit_of(input logic [7:0] v, input int k, input bit lsb);
    if (k < 0 || k > 7) return 1'b0;
    return lsb ? v[k] : v[7-k];
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench-side serial peer for master mode
  logic [7:0] bm_tx = '0, bm_rx = '0;
  bit   bm_lsb = 1'b0, prev_sck = 1'b0, prev_mosi = 1'b0;
  int   bm_base = 0, fall_cnt = 0, rise_cnt = 0, bad_mosi = 0, ss_cycles = 0;

  assign miso_i = bit_of(bm_tx, fall_cnt - bm_base, bm_lsb);

  always @(negedge clk) begin
    if (!ss_n_o) ss_cycles++;
    if (!prev_sck && sck_o) begin
      rise_cnt++;
      if (mosi_o !== prev_mosi) bad_mosi++;
      bm_rx = bm_lsb ? {mosi_o, bm_rx[7:1]} : {bm_rx[6:0], mosi_o};
    end
    if (prev_sck && !sck_o) fall_cnt++;
    prev_sck  = sck_o;
    prev_mosi = mosi_o;
  end

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic master_frame(input logic [7:0] ctx, input logic [7:0] btx,
                              input logic [1:0] sel, input bit dbl, input bit lsb,
                              input bit collide);
    int c0, r0, b0, dv;
    logic [7:0] st, rd;
    cpu_write(A_CTRL, {2'b00, dbl, sel, lsb, 1'b1, 1'b1});
    bm_tx = btx; bm_lsb = lsb; bm_base = fall_cnt;
    c0 = ss_cycles; r0 = rise_cnt; b0 = bad_mosi;
    cpu_write(A_DATA, ctx);
    if (collide) begin
      repeat (5) @(negedge clk);
      cpu_write(A_DATA, ~ctx);
    end
    while (!ss_n_o) @(negedge clk);
    dv = exp_div(sel, dbl);
    check(ss_cycles - c0 == 8 * dv, "R3 frame length", ss_cycles - c0, 8 * dv);
    check(rise_cnt - r0 == 8, "R4 sck pulses", rise_cnt - r0, 8);
    check(bad_mosi == b0, "R4 mosi stable at rise", bad_mosi - b0, 0);
    check(sck_o == 1'b0, "R4 sck rests low", sck_o, 0);
    if (lsb) check(bm_rx == ctx, "R2 sent byte lsb first", bm_rx, ctx);
    else     check(bm_rx == ctx, "R1 sent byte msb first", bm_rx, ctx);
    if (collide) check(bm_rx == ctx, "R7 shifted byte untouched", bm_rx, ctx);
    cpu_read(A_STAT, st);
    check(st[7] == 1'b1, "R5 done flag", st[7], 1);
    check(st[6] == collide, "R7 collision flag", st[6], collide);
    cpu_read(A_DATA, rd);
    if (lsb) check(rd == btx, "R2 received byte", rd, btx);
    else     check(rd == btx, "R1 received byte", rd, btx);
    cpu_read(A_STAT, st);
    check(st[7:6] == 2'b00, "R6 flags cleared", st[7:6], 0);
  endtask

  task automatic slave_frame(input logic [7:0] mtx, input logic [7:0] stx, input bit lsb,
                             input int nbits, output logic [7:0] got, output int oe_low);
    got = '0; oe_low = 0;
    cpu_write(A_CTRL, {2'b00, 1'b0, 2'b00, lsb, 1'b0, 1'b1});
    cpu_write(A_DATA, stx);
    ss_n_i = 1'b0;
    for (int k = 0; k < nbits; k++) begin
      mosi_i = bit_of(mtx, k, lsb);
      repeat (8) @(negedge clk);
      if (lsb) got[k] = miso_o; else got[7-k] = miso_o;
      if (!miso_oe) oe_low++;
      sck_i = 1'b1;
      repeat (8) @(negedge clk);
      sck_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    ss_n_i = 1'b1;
    repeat (6) @(negedge clk);
  endtask

  initial begin
    logic [7:0] st, rd, got;
    int oe_low;
    void'($urandom(32'd4021));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // Reset state
    cpu_read(A_STAT, st);
    check(st == 8'h00, "R5 status after reset", st, 0);
    check(ss_n_o && !sck_o, "R4 idle pins after reset", {ss_n_o, sck_o}, 2'b10);
    check(!miso_oe, "R10 oe after reset", miso_oe, 0);

    // R11: disabled block ignores data write
    cpu_write(A_CTRL, 8'h02);
    begin
      int r0 = rise_cnt, c0 = ss_cycles;
      cpu_write(A_DATA, 8'hA5);
      repeat (40) @(negedge clk);
      check(ss_cycles == c0, "R11 no select while disabled", ss_cycles - c0, 0);
      check(rise_cnt == r0, "R11 no sck while disabled", rise_cnt - r0, 0);
    end

    // Directed corners: fastest and slowest rates, both orders
    master_frame(8'h81, 8'h3C, 2'd0, 1'b1, 1'b0, 1'b0);
    master_frame(8'h01, 8'h80, 2'd3, 1'b0, 1'b1, 1'b0);
    // Collision during a frame
    master_frame(8'h5A, 8'hC3, 2'd1, 1'b0, 1'b0, 1'b1);

    // R6: data access without prior status read keeps the flag
    cpu_write(A_CTRL, 8'h03);
    bm_tx = 8'h11; bm_lsb = 1'b0; bm_base = fall_cnt;
    cpu_write(A_DATA, 8'h22);
    while (!ss_n_o) @(negedge clk);
    cpu_read(A_DATA, rd);
    check(rd == 8'h11, "R5 received byte readable", rd, 8'h11);
    cpu_read(A_STAT, st);
    check(st[7] == 1'b1, "R6 bare data access keeps flag", st[7], 1);
    repeat (30) @(negedge clk);
    cpu_read(A_DATA, rd);
    check(rd == 8'h11, "R5 received byte held", rd, 8'h11);
    cpu_read(A_STAT, st);
    check(st[7] == 1'b0, "R6 status then data clears", st[7], 0);

    // Random master frames
    for (int i = 0; i < 8; i++) begin
      master_frame(8'($urandom), 8'($urandom), 2'($urandom % 4), 1'($urandom % 2),
                   1'($urandom % 2), 1'b0);
    end

    // Slave frames
    for (int i = 0; i < 4; i++) begin
      logic [7:0] mtx, stx;
      bit lsb;
      mtx = (i == 0) ? 8'h96 : 8'($urandom);
      stx = (i == 0) ? 8'h4B : 8'($urandom);
      lsb = (i == 1) ? 1'b1 : ((i == 0) ? 1'b0 : 1'($urandom % 2));
      slave_frame(mtx, stx, lsb, 8, got, oe_low);
      check(got == stx, "R8 slave sends loaded byte", got, stx);
      check(oe_low == 0, "R10 oe while selected", oe_low, 0);
      check(!miso_oe, "R10 oe released on deselect", miso_oe, 0);
      cpu_read(A_STAT, st);
      check(st[7] == 1'b1, "R8 slave done flag", st[7], 1);
      cpu_read(A_DATA, rd);
      check(rd == mtx, "R8 slave received byte", rd, mtx);
    end

    // R9: aborted slave frame, then a full one
    slave_frame(8'hF0, 8'h0F, 1'b0, 3, got, oe_low);
    cpu_read(A_STAT, st);
    check(st[7] == 1'b0, "R9 partial frame no done", st[7], 0);
    slave_frame(8'h6D, 8'hB2, 1'b0, 8, got, oe_low);
    cpu_read(A_STAT, st);
    check(st[7] == 1'b1, "R9 next frame completes", st[7], 1);
    cpu_read(A_DATA, rd);
    check(rd == 8'h6D, "R9 next frame received", rd, 8'h6D);
    check(got == 8'hB2, "R9 next frame sent", got, 8'hB2);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(negedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule